// File: doc/BRIEF.md
# Asynchronous Set/Clear Flag Synchronizer

This block keeps a single status flag in the system clock domain. The flag is driven by two request lines that arrive with no fixed relation to the clock: one sets the flag and one clears it. In the default mode each request line has a capture stage. The capture stage is a flop clocked by the rising edge of the request, so a pulse shorter than one clock period still leaves a mark. That mark then passes through a multi-stage synchronizer. After the synchronizer the two requests drive a clocked set/clear register, which holds the flag.

A parameter selects a lighter mode for request lines whose pulses are known to last longer than a clock period. In that mode the raw lines go straight into the synchronizers and there is no capture stage. A synchronous load port lets clocked logic write the flag directly. A second output shows the loaded value in the same cycle it is requested. Logic that samples on the next clock edge therefore sees a write without waiting for the register.

Top module: `async_flag_sync`

## Requirements
- R1: While `rst` is high at a rising edge, the flag is 0 after that edge, and this takes priority over every other input. With `load_en` low, `flag_now` is then 0 too.
- R2: In capture mode, a set pulse that starts and ends between two clock edges makes `flag` go to 1 at the (SYNC_DEPTH+1)-th rising edge after the pulse, that is the third edge for the default depth of 2. The flag is still 0 after the edge before that one.
- R3: In capture mode, a clear pulse that lies between two edges makes `flag` go to 0 with the same latency as R2.
- R4: In level mode (MODE = LEVEL_ONLY), the raw request lines are synchronized directly. A pulse that does not span a rising edge has no effect on `flag`. A request held high sets the flag SYNC_DEPTH+1 edges after it rises.
- R5: In capture mode, the capture flop is not released while its request input is still high. A set input that is held high keeps re-asserting the flag, even after a load of 0. Once the input has gone low and the release has completed, the flag stays at whatever was last written.
- R6: When the synchronized set and the synchronized clear are active in the same cycle, the clear wins and the flag becomes 0.
- R7: While `load_en` is high, `flag_now` equals `load_val` in the same cycle. At the next rising edge `flag` takes that value.
- R8: `load_en` takes priority over both synchronized requests. After the load cycle, a set request that is still active takes effect again at the following edge.
- R9: While `load_en` is low, `flag_now` equals `flag`.
- R10: After a capture has been released, a new narrow pulse on the same line is caught again with the latency of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| set_async | input | 1 | Asynchronous set request, active high |
| clr_async | input | 1 | Asynchronous clear request, active high |
| load_en | input | 1 | Synchronous write enable for the flag |
| load_val | input | 1 | Value written when `load_en` is high |
| flag | output | 1 | Registered flag |
| flag_now | output | 1 | Same-cycle view: `load_val` while loading, else `flag` |

## Verification
Three cases can land in the same clock cycle, and each has a fixed winner.

- **Set and clear together.** The bench fires narrow set and clear pulses inside one clock period, so both synchronized requests arrive at the register on the same edge. Starting from a flag loaded to 1, the flag must go to 0.
- **Load and synchronized set together.** The bench times a load of 0 to hit exactly the edge at which a captured set comes out of the synchronizer. The flag must show the loaded 0 for one cycle. It must then return to 1 on the next edge, because the set is still active.
- **Level mode.** A second instance in level mode receives the same stimulus. It confirms that narrow pulses are ignored there, while held requests still act.

// File: rtl/afs_pkg.sv
package afs_pkg;

    typedef enum logic {
        CATCH_EDGE = 1'b0,
        LEVEL_ONLY = 1'b1
    } req_mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_LOAD = 2'd3
    } flag_act_e;

    typedef struct packed {
        logic clr;
        logic set;
    } req_pair_t;

    localparam int unsigned CH_SET = 0;
    localparam int unsigned CH_CLR = 1;
    localparam int unsigned NUM_CH = 2;

    // Load first, then clear, then set, else hold.
    function automatic flag_act_e pick_action(logic ld, logic s, logic c);
        flag_act_e a;
        if (ld)
            a = ACT_LOAD;
        else if (c)
            a = ACT_CLR;
        else if (s)
            a = ACT_SET;
        else
            a = ACT_HOLD;
        return a;
    endfunction

endpackage

// File: rtl/afs_sync_chain.sv
module afs_sync_chain #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int unsigned TOP = DEPTH - 1;

    logic [TOP:0] stage;

    always_ff @(posedge clk) begin
        if (rst)
            stage <= '0;
        else
            stage <= {stage[TOP-1:0], d};
    end

    assign q = stage[TOP];

endmodule

// File: rtl/afs_channel.sv
module afs_channel
    import afs_pkg::*;
#(
    parameter req_mode_e   MODE  = CATCH_EDGE,
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_raw,
    output logic req_sync
);
    generate
        if (MODE == CATCH_EDGE) begin : g_catch
            logic held;
            logic rel_q;
            logic held_sync;
            logic lvl_sync;

            // Edge-clocked capture flop: set by the request edge, emptied by a clocked release.
            always_ff @(posedge req_raw or posedge rel_q) begin
                if (rel_q)
                    held <= 1'b0;
                else
                    held <= 1'b1;
            end

            afs_sync_chain #(.DEPTH(DEPTH)) u_held_sync (
                .clk (clk),
                .rst (rst),
                .d   (held),
                .q   (held_sync)
            );

            afs_sync_chain #(.DEPTH(DEPTH)) u_level_sync (
                .clk (clk),
                .rst (rst),
                .d   (req_raw),
                .q   (lvl_sync)
            );

            // Release only once the capture has been seen and the line is low again.
            always_ff @(posedge clk) begin
                rel_q <= rst | (held_sync & ~lvl_sync);
            end

            assign req_sync = held_sync;
        end else begin : g_level
            afs_sync_chain #(.DEPTH(DEPTH)) u_level_sync (
                .clk (clk),
                .rst (rst),
                .d   (req_raw),
                .q   (req_sync)
            );
        end
    endgenerate

endmodule

// File: rtl/afs_flag_reg.sv
module afs_flag_reg
    import afs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_s,
    input  logic clr_s,
    input  logic load_en,
    input  logic load_val,
    output logic flag,
    output logic flag_now
);
    flag_act_e act;

    always_comb begin
        act = pick_action(load_en, set_s, clr_s);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else begin
            unique case (act)
                ACT_LOAD: flag <= load_val;
                ACT_CLR:  flag <= 1'b0;
                ACT_SET:  flag <= 1'b1;
                default:  flag <= flag;
            endcase
        end
    end

    // Transparent view: pass the write while loading, else show the stored bit.
    always_comb begin
        flag_now = load_en ? load_val : flag;
    end

    AST_RST_CLEARS: assert property (@(posedge clk) rst |=> !flag); // R1
    AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !clr_s && set_s) |=> flag); // R2
    AST_CLR_OVER_SET: assert property (@(posedge clk) disable iff (rst)
        (!load_en && clr_s) |=> !flag); // R6
    AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (flag == $past(load_val))); // R8
    AST_FAST_STORED: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (flag == $past(flag_now))); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !clr_s && !set_s) |=> $stable(flag)); // R5

endmodule

// File: rtl/async_flag_sync.sv
module async_flag_sync
    import afs_pkg::*;
#(
    parameter req_mode_e   MODE       = CATCH_EDGE,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic set_async,
    input  logic clr_async,
    input  logic load_en,
    input  logic load_val,
    output logic flag,
    output logic flag_now
);
    logic [NUM_CH-1:0] raw_vec;
    logic [NUM_CH-1:0] sync_vec;
    req_pair_t         synced;

    assign raw_vec[CH_SET] = set_async;
    assign raw_vec[CH_CLR] = clr_async;

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            afs_channel #(
                .MODE  (MODE),
                .DEPTH (SYNC_DEPTH)
            ) u_channel (
                .clk      (clk),
                .rst      (rst),
                .req_raw  (raw_vec[ch]),
                .req_sync (sync_vec[ch])
            );
        end
    endgenerate

    assign synced.set = sync_vec[CH_SET];
    assign synced.clr = sync_vec[CH_CLR];

    afs_flag_reg u_flag (
        .clk      (clk),
        .rst      (rst),
        .set_s    (synced.set),
        .clr_s    (synced.clr),
        .load_en  (load_en),
        .load_val (load_val),
        .flag     (flag),
        .flag_now (flag_now)
    );

    AST_FAST_IDLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        !load_en |-> (flag_now == flag)); // R9

endmodule

// File: tb/async_flag_sync_tb.sv
`timescale 1ns/100ps
module async_flag_sync_tb;
    import afs_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic set_async = 1'b0;
    logic clr_async = 1'b0;
    logic load_en = 1'b0;
    logic load_val = 1'b0;
    logic flag, flag_now, flag_w, flag_now_w;

    int cyc = 0;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    async_flag_sync #(.MODE(CATCH_EDGE), .SYNC_DEPTH(2)) u_dut (
        .clk(clk), .rst(rst), .set_async(set_async), .clr_async(clr_async),
        .load_en(load_en), .load_val(load_val), .flag(flag), .flag_now(flag_now));

    async_flag_sync #(.MODE(LEVEL_ONLY), .SYNC_DEPTH(2)) u_dut_w (
        .clk(clk), .rst(rst), .set_async(set_async), .clr_async(clr_async),
        .load_en(load_en), .load_val(load_val), .flag(flag_w), .flag_now(flag_now_w));

    typedef struct {
        int   at;
        int   which;
        logic fl;
        logic fs;
        int   req;
    } exp_t;

    exp_t sbq[$];
    exp_t cur;

    task automatic expect_at(input int k, input int which, input logic fl, input logic fs, input int req);
        exp_t e;
        e.at = cyc + k; e.which = which; e.fl = fl; e.fs = fs; e.req = req;
        sbq.push_back(e);
    endtask

    task automatic chk(input logic act, input logic exp, input int req, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // Monitor: compares scoreboard items away from the active edge.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].at <= cyc) begin
            cur = sbq.pop_front();
            if (cur.which == 0) begin
                chk(flag, cur.fl, cur.req, "flag (catch)");
                chk(flag_now, cur.fs, cur.req, "flag_now (catch)");
            end else begin
                chk(flag_w, cur.fl, cur.req, "flag (level)");
                chk(flag_now_w, cur.fs, cur.req, "flag_now (level)");
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic pulse_set();
        set_async = 1'b1; #0.5; set_async = 1'b0;
    endtask

    task automatic pulse_clr();
        clr_async = 1'b1; #0.5; clr_async = 1'b0;
    endtask

    task automatic pulse_both();
        set_async = 1'b1; clr_async = 1'b1; #0.5;
        set_async = 1'b0; clr_async = 1'b0;
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 4000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=<4000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        expect_at(1, 0, 1'b0, 1'b0, 1); // R1 reset state
        expect_at(1, 1, 1'b0, 1'b0, 1); // R1
        tick(2);

        // R2 narrow set: catch mode sets on third edge; R4 level mode ignores it
        pulse_set();
        expect_at(2, 0, 1'b0, 1'b0, 2); // R2
        expect_at(3, 0, 1'b1, 1'b1, 2); // R2
        expect_at(3, 1, 1'b0, 1'b0, 4); // R4
        expect_at(4, 0, 1'b1, 1'b1, 9); // R9
        tick(8);

        // R3 narrow clear
        pulse_clr();
        expect_at(2, 0, 1'b1, 1'b1, 3); // R3
        expect_at(3, 0, 1'b0, 1'b0, 3); // R3
        tick(8);

        // R10 re-arm after release
        pulse_set();
        expect_at(3, 0, 1'b1, 1'b1, 10); // R10
        tick(8);
        pulse_clr();
        expect_at(3, 0, 1'b0, 1'b0, 10); // R10
        tick(8);

        // R7 load: same-cycle view then stored
        load_en = 1'b1; load_val = 1'b1;
        #0.5;
        chk(flag_now, 1'b1, 7, "flag_now during load (catch)");   // R7
        chk(flag_now_w, 1'b1, 7, "flag_now during load (level)"); // R7
        chk(flag, 1'b0, 7, "flag before load edge");              // R7
        expect_at(1, 0, 1'b1, 1'b1, 7); // R7
        expect_at(1, 1, 1'b1, 1'b1, 7); // R7
        tick(1);
        load_en = 1'b0;
        tick(1);

        // R6 simultaneous set and clear: clear wins; R4 level mode ignores both
        pulse_both();
        expect_at(2, 0, 1'b1, 1'b1, 6); // R6
        expect_at(3, 0, 1'b0, 1'b0, 6); // R6
        expect_at(3, 1, 1'b1, 1'b1, 4); // R4
        tick(8);

        // R8 load of 0 on the same edge as the synchronized set
        pulse_set();
        tick(2);
        load_en = 1'b1; load_val = 1'b0;
        #0.5;
        chk(flag_now, 1'b0, 7, "flag_now shows load 0"); // R7
        expect_at(1, 0, 1'b0, 1'b0, 8); // R8
        expect_at(1, 1, 1'b0, 1'b0, 8); // R8
        tick(1);
        load_en = 1'b0;
        expect_at(1, 0, 1'b1, 1'b1, 8); // R8 set resumes
        tick(8);
        pulse_clr();
        expect_at(3, 0, 1'b0, 1'b0, 3); // R3
        tick(8);

        // R5 held set request
        set_async = 1'b1;
        expect_at(3, 0, 1'b1, 1'b1, 5); // R5
        expect_at(3, 1, 1'b1, 1'b1, 4); // R4 held request sets level mode
        tick(5);
        load_en = 1'b1; load_val = 1'b0;
        expect_at(1, 0, 1'b0, 1'b0, 5); // R5
        expect_at(1, 1, 1'b0, 1'b0, 5); // R5
        tick(1);
        load_en = 1'b0;
        expect_at(1, 0, 1'b1, 1'b1, 5); // R5 still held
        expect_at(1, 1, 1'b1, 1'b1, 5); // R5
        tick(3);
        set_async = 1'b0;
        tick(8);
        load_en = 1'b1; load_val = 1'b0;
        tick(1);
        load_en = 1'b0;
        expect_at(3, 0, 1'b0, 1'b0, 5); // R5 released, stays 0
        expect_at(3, 1, 1'b0, 1'b0, 5); // R5
        tick(5);

        // R1 reset overrides load
        load_en = 1'b1; load_val = 1'b1;
        tick(1);
        load_en = 1'b0;
        expect_at(1, 0, 1'b1, 1'b1, 7); // R7
        tick(1);
        rst = 1'b1; load_en = 1'b1; load_val = 1'b1;
        tick(1);
        rst = 1'b0; load_en = 1'b0;
        expect_at(0, 0, 1'b0, 1'b0, 1); // R1
        tick(3);

        if (sbq.size() > 0) begin
            total++; bad++;
            $display("FAIL R1 scoreboard: actual=%0d pending expected=0", sbq.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule